// File: doc/BRIEF.md
# Split Program/Data Memory Map with Output Port

This block sits behind a small processor's address bus and turns one flat word address space into two halves. The lower half is a read-only program store whose contents are generated at elaboration from two parameters. The upper half is read/write data storage. The very top address also drives a 16-bit output register, so that a program can publish a value to the outside world with an ordinary store.

The output register is loaded by stores only. A load from the top address always returns the data-storage copy, never the register. Reads are synchronous: the processor presents an address at one rising edge and takes the data after that edge. Stores into the program half are dropped without effect. Reset clears the output register and the read data register but leaves data storage untouched.

Top module: `memmap_split`

## Requirements
- R1: While reset is high at a rising edge, `port_out` and `rd_data` become 0 after that edge.
- R2: A read at an address with bit 7 = 0 returns the program word `(ROM_SEED + idx * ROM_STEP) mod 2^16`. Here idx is address bits 6:0, and the defaults are ROM_SEED = 16'hA5C3 and ROM_STEP = 16'h0137.
- R3: A write to an address with bit 7 = 1 stores `wdata` in data storage at that address. A later read of that address returns it.
- R4: A write to an address with bit 7 = 0 has no effect. Program reads are unchanged, data storage is unchanged and `port_out` is unchanged.
- R5: A write to address 8'hFF sets `port_out` to `wdata` after that edge. It also stores the same value in data storage at 8'hFF.
- R6: A write to any address other than 8'hFF, or a cycle with no write, leaves `port_out` unchanged.
- R7: A read of 8'hFF returns the data-storage copy, even after a reset has cleared `port_out` to 0.
- R8: `rd_data` shows the word for the address sampled at the latest rising edge. It holds that word until the next rising edge.
- R9: A read and a write at the same data address in one cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Word address |
| wdata | input | 16 | Store data |
| we | input | 1 | Store strobe, sampled at the rising edge |
| rd_data | output | 16 | Registered read data |
| port_out | output | 16 | Memory-mapped output register |

## Verification
Every result is due exactly one rising edge after its stimulus. The read data for an address presented at edge N is compared 1 ns after edge N, and a store at edge N must show on `port_out` at that same sample point. The bench drives inputs at the falling edge and computes the expected read word from a model taken before the model is updated with that cycle's store. This reproduces the old-data rule for a read and write to the same address. A separate probe just before the next edge checks that the read data holds while the address has already moved on.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic {
      REG_PROG = 1'b0,
      REG_DATA = 1'b1
   } region_e;

   // Program word generator, evaluated at full 64-bit width; callers slice.
   function automatic logic [63:0] prog_word(input logic [63:0] seed,
                                             input logic [63:0] step,
                                             input logic [63:0] idx);
      return seed + idx * step;
   endfunction

endpackage

// File: rtl/memmap_decode.sv
module memmap_decode
   import memmap_pkg::*;
#(
   parameter int ADDR_W = 8,
   localparam int IDX_W = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output region_e           region,
   output logic [IDX_W-1:0]  idx,
   output logic              data_we,
   output logic              port_we
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

   always_comb begin
      region  = addr[ADDR_W-1] ? REG_DATA : REG_PROG;
      idx     = addr[IDX_W-1:0];
      data_we = we && (region == REG_DATA);
      port_we = we && (addr == TOP_ADDR);
   end
endmodule

// File: rtl/memmap_rom.sv
module memmap_rom
   import memmap_pkg::*;
#(
   parameter int          DATA_W   = 16,
   parameter int          IDX_W    = 7,
   parameter logic [63:0] ROM_SEED = 64'hA5C3,
   parameter logic [63:0] ROM_STEP = 64'h0137
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] q
);
   logic [63:0] word_full;

   always_comb word_full = prog_word(ROM_SEED, ROM_STEP, 64'(idx));

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= word_full[DATA_W-1:0];
   end
endmodule

// File: rtl/memmap_ram.sv
module memmap_ram #(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 7,
   parameter bit WR_FIRST  = 1'b0,
   localparam int DEPTH    = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   generate
      if (WR_FIRST) begin : g_write_first
         always_ff @(posedge clk) begin
            if (rst)     q <= '0;
            else if (we) q <= wdata;
            else         q <= mem[idx];
         end
      end else begin : g_read_first
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= mem[idx];
         end
      end
   endgenerate
endmodule

// File: rtl/memmap_port.sv
module memmap_port #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] port
);
   always_ff @(posedge clk) begin
      if (rst)     port <= '0;
      else if (we) port <= wdata;
   end

   // R5: a top-address store lands on the port one edge later
   a_r5_port_load: assert property (@(posedge clk) disable iff (rst)
      we |=> port == $past(wdata));

   // R6: without a top-address store the port holds
   a_r6_port_hold: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(port));
endmodule

// File: rtl/memmap_split.sv
module memmap_split
   import memmap_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 16,
   parameter logic [63:0] ROM_SEED = 64'hA5C3,
   parameter logic [63:0] ROM_STEP = 64'h0137,
   parameter bit          WR_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] port_out
);
   localparam int IDX_W = ADDR_W - 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
         $error("memmap_split: ADDR_W must be in 2..16");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("memmap_split: DATA_W must be in 1..64");
      end
   endgenerate

   region_e           region, region_q;
   logic [IDX_W-1:0]  idx;
   logic              data_we, port_we;
   logic [DATA_W-1:0] prog_q, data_q;

   memmap_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr(addr), .we(we), .region(region), .idx(idx),
      .data_we(data_we), .port_we(port_we));

   memmap_rom #(.DATA_W(DATA_W), .IDX_W(IDX_W),
                .ROM_SEED(ROM_SEED), .ROM_STEP(ROM_STEP)) u_rom (
      .clk(clk), .rst(rst), .idx(idx), .q(prog_q));

   memmap_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WR_FIRST(WR_FIRST)) u_ram (
      .clk(clk), .rst(rst), .we(data_we), .idx(idx), .wdata(wdata), .q(data_q));

   memmap_port #(.DATA_W(DATA_W)) u_port (
      .clk(clk), .rst(rst), .we(port_we), .wdata(wdata), .port(port_out));

   always_ff @(posedge clk) begin
      if (rst) region_q <= REG_PROG;
      else     region_q <= region;
   end

   always_comb rd_data = (region_q == REG_DATA) ? data_q : prog_q;

   // R4: storage write strobe only ever fires for upper-half addresses
   a_r4_data_region_only: assert property (@(posedge clk) disable iff (rst)
      data_we |-> addr[ADDR_W-1]);

   // R5: a port store is also a storage store
   a_r5_port_also_data: assert property (@(posedge clk) disable iff (rst)
      port_we |-> data_we);

   // R2/R8: a program-half read appears one edge later
   a_r8_prog_latency: assert property (@(posedge clk) disable iff (rst)
      !addr[ADDR_W-1] |=> rd_data == $past(prog_q_next()));

   function automatic logic [DATA_W-1:0] prog_q_next();
      logic [63:0] w;
      w = ROM_SEED + 64'(addr[IDX_W-1:0]) * ROM_STEP;
      return w[DATA_W-1:0];
   endfunction
endmodule

// File: tb/memmap_split_test.sv
module memmap_split_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        we = 1'b0;
   logic [15:0] rd_data, port_out;

   memmap_split uut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
                     .we(we), .rd_data(rd_data), .port_out(port_out));

   always #5 clk = ~clk;

   int          checks = 0, fails = 0;
   bit          done = 1'b0;
   logic [15:0] ram_m [128];
   bit          ram_v [128];
   logic [15:0] port_m = '0;
   logic [15:0] last_rd;

   function automatic logic [15:0] exp_prog(input logic [6:0] i);
      logic [31:0] t;
      t = 32'hA5C3 + 32'(i) * 32'h0137;
      return t[15:0];
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; we = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      port_m = '0;
      chk("R1 port_out after reset", port_out, 16'h0000);
      chk("R1 rd_data after reset", rd_data, 16'h0000);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic op(input logic [7:0] a, input bit w, input logic [15:0] d,
                     input string rlabel);
      logic [15:0] rexp;
      bit          rval;
      string       lbl;
      @(negedge clk);
      addr = a; we = w; wdata = d;
      @(posedge clk);
      if (!a[7]) begin rexp = exp_prog(a[6:0]); rval = 1'b1; end
      else       begin rexp = ram_m[a[6:0]];    rval = ram_v[a[6:0]]; end
      if (w && a[7]) begin ram_m[a[6:0]] = d; ram_v[a[6:0]] = 1'b1; end
      if (w && a == 8'hFF) port_m = d;
      #1;
      lbl = (rlabel != "") ? rlabel : (a[7] ? "R3 data read" : "R2 program read");
      if (rval) chk(lbl, rd_data, rexp);
      chk((w && a == 8'hFF) ? "R5 port load" : "R6 port hold", port_out, port_m);
      last_rd = rd_data;
      @(negedge clk);
      we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      for (int i = 0; i < 128; i++) ram_v[i] = 1'b0;
      void'($urandom(32'd2024));
      do_reset();

      op(8'h00, 0, 16'h0, "R2 program read 0x00");
      op(8'h7F, 0, 16'h0, "R2 program read 0x7F");
      op(8'h40, 0, 16'h0, "R2 program read 0x40");

      op(8'h85, 1, 16'h1234, "");
      op(8'h85, 0, 16'h0, "R3 read back 0x85");
      op(8'h80, 1, 16'h0F0F, "");
      op(8'h80, 0, 16'h0, "R3 read back 0x80");

      op(8'h05, 1, 16'hBEEF, "R4 program write ignored");
      op(8'h05, 0, 16'h0, "R4 program word intact");
      op(8'h85, 0, 16'h0, "R4 data word intact");
      chk("R4 port intact", port_out, 16'h0000);

      op(8'hFF, 1, 16'hCAFE, "");
      chk("R5 port value", port_out, 16'hCAFE);
      op(8'hFF, 0, 16'h0, "R5 data copy at 0xFF");
      op(8'h90, 1, 16'h1111, "");
      chk("R6 port kept after other store", port_out, 16'hCAFE);

      op(8'h85, 1, 16'h5555, "R9 old data on same-cycle write");
      op(8'h85, 0, 16'h0, "R9 new data next read");

      // R8: data holds while the next address is already presented
      op(8'h10, 0, 16'h0, "R8 program read 0x10");
      @(negedge clk);
      addr = 8'h11;
      #3;
      chk("R8 rd_data held before next edge", rd_data, exp_prog(7'h10));
      op(8'h11, 0, 16'h0, "R8 next address");

      // R7: port cleared by reset while storage keeps its copy
      op(8'hFF, 1, 16'hABCD, "");
      do_reset();
      op(8'hFF, 0, 16'h0, "R7 read 0xFF gives data copy");
      chk("R7 port still cleared", port_out, 16'h0000);

      for (int n = 0; n < 600; n++) begin
         logic [7:0]  ra;
         logic [15:0] rd;
         bit          rw;
         ra = 8'($urandom());
         if ((n % 16) == 0) ra = 8'hFF;
         rw = bit'($urandom() % 2);
         rd = 16'($urandom());
         op(ra, rw, rd, "");
      end

      summary();
   end
endmodule